// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is the sending half of an interprocessor interrupt path. A local CPU composes an interrupt message through two 32-bit memory-mapped command words. First it writes the destination word, which stages the target processor ID. Then it writes the command word, which holds the vector, the delivery mode, the trigger mode, the level and a destination shorthand. Writing the command word launches the message. The block takes a snapshot of both words, presents the message on a parallel valid/ready output port, and keeps a busy flag set until the receiver accepts the message.

Software polls the busy flag in the command word before it issues the next command. If the command word is written while a message is still in flight, the write is dropped and a sticky send-error flag is raised in a separate error word. A write of any value to the error word clears the flag. The destination shorthand can override the staged ID with one of three choices: this processor's own ID, taken from a strap input, or a broadcast ID for either of the two "all" forms. The shorthand code is also passed on the port, so that a receiver can tell "all including self" apart from "all excluding self".

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid` is 0, and the command word (0x300), the destination word (0x310) and the error word (0x280) all read 0.
- R2: A write to the destination word stores data bits 31:24 as the staged ID. A read returns the ID in bits 31:24 and zero in every other bit.
- R3: A command-word write while the unit is idle raises `msg_valid` on the next cycle. The message carries these fields from the written data: vector bits 7:0, mode bits 10:8, level bit 14 (1 = assert), trigger bit 15 (1 = level) and shorthand bits 19:18. While the message is pending, the command word reads with bit 12 (busy) set.
- R4: `msg_dest` depends on the shorthand. Code 00 gives the staged ID, code 01 gives `self_id`, and codes 10 and 11 give the broadcast ID (all ones). `msg_short` carries the code itself.
- R5: While `msg_valid` is high and `msg_ready` is low, the message fields and `msg_valid` hold steady. After the clock edge where both are high, `msg_valid` and busy bit 12 are 0.
- R6: A command-word write while busy is ignored. The pending message and the command-word readback stay unchanged, and bit 0 of the error word is set.
- R7: The send-error bit stays set until a write of any value to the error word, which clears it.
- R8: In the command word, reserved bits (31:20, 13, 11) and the remote-read status bits 17:16 always read 0, even after a write of all ones.
- R9: A destination-word write while busy updates the staged ID but leaves `msg_dest` of the pending message unchanged. The new ID is used by the next launch.
- R10: A read of an unmapped offset returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | This processor's ID, used for the self shorthand |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| msg_valid | output | 1 | Message pending on the port |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_dest | output | 8 | Resolved destination ID |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_trig | output | 1 | Trigger mode, 1 = level |
| msg_level | output | 1 | Level, 1 = assert |
| msg_short | output | 2 | Destination shorthand code |

## Verification
A corrupted busy flag is visible at once, because `msg_valid` and bit 12 of the command word come from the same state. A flag stuck high leaves `msg_valid` high one cycle after a handshake. A flag that clears too early drops a message that is still held back by `msg_ready`. A payload snapshot taken at the wrong time shows up as a field that changes while the message is pending, or as a `msg_dest` that follows a later destination-word write. Both can be seen on the first sample after the offending write. A wrong error-flag path shows up on the next read of the error word.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int WORD_W  = 32;
   localparam int VEC_W   = 8;
   localparam int MODE_W  = 3;
   localparam int SH_W    = 2;

   // Bit positions in the command word
   localparam int VEC_LSB  = 0;
   localparam int MODE_LSB = 8;
   localparam int BUSY_BIT = 12;
   localparam int LVL_BIT  = 14;
   localparam int TRIG_BIT = 15;
   localparam int RRS_LSB  = 16;
   localparam int SH_LSB   = 18;

   typedef enum logic [SH_W-1:0] {
      SH_FIELD = 2'b00,
      SH_SELF  = 2'b01,
      SH_ALL   = 2'b10,
      SH_OTHER = 2'b11
   } ipi_short_e;

   typedef struct packed {
      ipi_short_e              shorthand;
      logic                    trig;
      logic                    level;
      logic [MODE_W-1:0]       mode;
      logic [VEC_W-1:0]        vector;
   } ipi_cmd_t;

   function automatic ipi_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
      ipi_cmd_t c;
      c.vector    = w[VEC_LSB +: VEC_W];
      c.mode      = w[MODE_LSB +: MODE_W];
      c.level     = w[LVL_BIT];
      c.trig      = w[TRIG_BIT];
      c.shorthand = ipi_short_e'(w[SH_LSB +: SH_W]);
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] pack_cmd(input ipi_cmd_t c, input logic busy);
      logic [WORD_W-1:0] w;
      w = '0;
      w[VEC_LSB +: VEC_W]   = c.vector;
      w[MODE_LSB +: MODE_W] = c.mode;
      w[BUSY_BIT]           = busy;
      w[LVL_BIT]            = c.level;
      w[TRIG_BIT]           = c.trig;
      w[RRS_LSB +: 2]       = 2'b00;
      w[SH_LSB +: SH_W]     = c.shorthand;
      return w;
   endfunction
endpackage

// File: rtl/ipi_reg_file.sv
module ipi_reg_file
   import ipi_pkg::*;
#(
   parameter int              ADDR_W  = 12,
   parameter int              ID_W    = 8,
   parameter logic [ADDR_W-1:0] LO_OFS  = 12'h300,
   parameter logic [ADDR_W-1:0] HI_OFS  = 12'h310,
   parameter logic [ADDR_W-1:0] ERR_OFS = 12'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              busy,
   input  ipi_cmd_t          cur_cmd,
   output logic              accept,
   output ipi_cmd_t          new_cmd,
   output logic [ID_W-1:0]   staged_id,
   output logic              err_flag
);
   localparam int DEST_LSB = WORD_W - 8;

   logic hit_lo, hit_hi, hit_err;
   logic [ID_W-1:0] id_q;
   logic            err_q;

   assign hit_lo  = bus_addr == LO_OFS;
   assign hit_hi  = bus_addr == HI_OFS;
   assign hit_err = bus_addr == ERR_OFS;

   assign accept  = bus_wr && hit_lo && !busy;
   assign new_cmd = unpack_cmd(bus_wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q  <= '0;
         err_q <= 1'b0;
      end else begin
         if (bus_wr && hit_hi)
            id_q <= bus_wdata[DEST_LSB +: ID_W];
         if (bus_wr && hit_lo && busy)
            err_q <= 1'b1;
         else if (bus_wr && hit_err)
            err_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_lo)
         bus_rdata = pack_cmd(cur_cmd, busy);
      else if (hit_hi)
         bus_rdata[DEST_LSB +: ID_W] = id_q;
      else if (hit_err)
         bus_rdata[0] = err_q;
   end

   assign staged_id = id_q;
   assign err_flag  = err_q;
endmodule

// File: rtl/ipi_launch_ctl.sv
module ipi_launch_ctl
   import ipi_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  ipi_cmd_t        new_cmd,
   input  logic [ID_W-1:0] staged_id,
   input  logic            ready,
   output logic            busy,
   output ipi_cmd_t        cmd_q,
   output logic [ID_W-1:0] id_snap
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cmd_q   <= '0;
         id_snap <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         cmd_q   <= new_cmd;
         id_snap <= staged_id;
      end else if (busy_q && ready) begin
         busy_q  <= 1'b0;
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
   import ipi_pkg::*;
#(
   parameter int              ID_W     = 8,
   parameter logic [ID_W-1:0] BCAST_ID = '1
) (
   input  ipi_short_e      shorthand,
   input  logic [ID_W-1:0] field_id,
   input  logic [ID_W-1:0] self_id,
   output logic [ID_W-1:0] dest
);
   always_comb begin
      unique case (shorthand)
         SH_FIELD: dest = field_id;
         SH_SELF:  dest = self_id;
         default:  dest = BCAST_ID;
      endcase
   end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
   import ipi_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                ID_W     = 8,
   parameter logic [ADDR_W-1:0] LO_OFS   = 12'h300,
   parameter logic [ADDR_W-1:0] HI_OFS   = 12'h310,
   parameter logic [ADDR_W-1:0] ERR_OFS  = 12'h280,
   parameter logic [ID_W-1:0]   BCAST_ID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   self_id,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [ID_W-1:0]   msg_dest,
   output logic [7:0]        msg_vector,
   output logic [2:0]        msg_mode,
   output logic              msg_trig,
   output logic              msg_level,
   output logic [1:0]        msg_short
);
   initial begin
      if (ID_W < 1 || ID_W > 8)
         $fatal(1, "ipi_cmd_unit: ID_W must be 1..8");
      if (ADDR_W < 10)
         $fatal(1, "ipi_cmd_unit: ADDR_W too small for register offsets");
      if (LO_OFS == HI_OFS || LO_OFS == ERR_OFS || HI_OFS == ERR_OFS)
         $fatal(1, "ipi_cmd_unit: register offsets must differ");
   end

   logic            busy, accept, err_flag;
   ipi_cmd_t        new_cmd, cmd_q;
   logic [ID_W-1:0] staged_id, id_snap;

   ipi_reg_file #(
      .ADDR_W(ADDR_W), .ID_W(ID_W),
      .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .ERR_OFS(ERR_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .busy(busy), .cur_cmd(cmd_q),
      .accept(accept), .new_cmd(new_cmd),
      .staged_id(staged_id), .err_flag(err_flag)
   );

   ipi_launch_ctl #(.ID_W(ID_W)) u_launch (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .new_cmd(new_cmd), .staged_id(staged_id),
      .ready(msg_ready),
      .busy(busy), .cmd_q(cmd_q), .id_snap(id_snap)
   );

   ipi_dest_resolve #(.ID_W(ID_W), .BCAST_ID(BCAST_ID)) u_dest (
      .shorthand(cmd_q.shorthand), .field_id(id_snap),
      .self_id(self_id), .dest(msg_dest)
   );

   assign msg_valid  = busy;
   assign msg_vector = cmd_q.vector;
   assign msg_mode   = cmd_q.mode;
   assign msg_trig   = cmd_q.trig;
   assign msg_level  = cmd_q.level;
   assign msg_short  = cmd_q.shorthand;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
   parameter int                ADDR_W   = 12,
   parameter int                ID_W     = 8,
   parameter logic [ADDR_W-1:0] LO_OFS   = 12'h300,
   parameter logic [ADDR_W-1:0] ERR_OFS  = 12'h280,
   parameter logic [ID_W-1:0]   BCAST_ID = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [ID_W-1:0]   self_id,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [ID_W-1:0]   msg_dest,
   input logic [7:0]        msg_vector,
   input logic [2:0]        msg_mode,
   input logic [1:0]        msg_short,
   input logic              err_flag
);
   p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == LO_OFS && !msg_valid) |=> msg_valid);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
         && $stable(msg_dest) && $stable(msg_mode) && $stable(msg_short)));

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);

   p_busy_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == LO_OFS && msg_valid) |=> err_flag);

   p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ERR_OFS) |=> !err_flag);

   p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_short[1]) |-> msg_dest == BCAST_ID);

   p_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_short == 2'b01) |-> msg_dest == self_id);

   p_rrs_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == LO_OFS) |-> bus_rdata[17:16] == 2'b00);
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(
   .ADDR_W(ADDR_W), .ID_W(ID_W), .LO_OFS(LO_OFS),
   .ERR_OFS(ERR_OFS), .BCAST_ID(BCAST_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .self_id(self_id),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
   .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_short(msg_short),
   .err_flag(err_flag)
);

// File: tb/sim_ipi_cmd_unit.sv
`timescale 1ns/1ps
module sim_ipi_cmd_unit;
   localparam logic [11:0] A_LO  = 12'h300;
   localparam logic [11:0] A_HI  = 12'h310;
   localparam logic [11:0] A_ERR = 12'h280;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  self_id = 8'h17;
   logic        bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid, msg_ready = 0;
   logic [7:0]  msg_dest, msg_vector;
   logic [2:0]  msg_mode;
   logic        msg_trig, msg_level;
   logic [1:0]  msg_short;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ipi_cmd_unit u0 (
      .clk(clk), .rst_n(rst_n), .self_id(self_id),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_mode(msg_mode),
      .msg_trig(msg_trig), .msg_level(msg_level), .msg_short(msg_short)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // inputs change on negedge; one posedge later, sample at the following negedge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic handshake;
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 valid", {31'b0, msg_valid}, 0);
      rd(A_LO, d);  chk("R1 lo", d, 0);
      rd(A_HI, d);  chk("R1 hi", d, 0);
      rd(A_ERR, d); chk("R1 err", d, 0);
   endtask

   task automatic t_high;
      logic [31:0] d;
      wr(A_HI, 32'h5A12_3456);
      rd(A_HI, d); chk("R2 hi readback", d, 32'h5A00_0000);
   endtask

   task automatic t_launch;
      logic [31:0] d;
      wr(A_LO, 32'h0000_C531);
      chk("R3 valid", {31'b0, msg_valid}, 1);
      chk("R3 vector", {24'b0, msg_vector}, 32'h31);
      chk("R3 mode", {29'b0, msg_mode}, 5);
      chk("R3 trig/level", {30'b0, msg_trig, msg_level}, 3);
      chk("R4 field dest", {24'b0, msg_dest}, 32'h5A);
      rd(A_LO, d); chk("R3 busy readback", d, 32'h0000_D531);
      handshake;
      chk("R5 released", {31'b0, msg_valid}, 0);
      rd(A_LO, d); chk("R5 busy clear", d, 32'h0000_C531);
   endtask

   task automatic t_shorthand;
      logic [7:0] exp_d [4] = '{8'h5A, 8'h17, 8'hFF, 8'hFF};
      for (int s = 0; s < 4; s++) begin
         wr(A_LO, (32'(s) << 18) | 32'h40);
         chk("R4 short code", {30'b0, msg_short}, 32'(s));
         chk("R4 dest", {24'b0, msg_dest}, {24'b0, exp_d[s]});
         handshake;
      end
   endtask

   task automatic t_hold;
      logic [31:0] d;
      wr(A_LO, 32'h0000_0277);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R5 hold valid", {31'b0, msg_valid}, 1);
         chk("R5 hold vector", {24'b0, msg_vector}, 32'h77);
         rd(A_LO, d); chk("R5 hold busy", {31'b0, d[12]}, 1);
      end
      handshake;
      chk("R5 after hold", {31'b0, msg_valid}, 0);
   endtask

   task automatic t_busy_write;
      logic [31:0] d;
      wr(A_LO, 32'h0000_0111);
      wr(A_LO, 32'h0000_0622);
      chk("R6 vector kept", {24'b0, msg_vector}, 32'h11);
      chk("R6 mode kept", {29'b0, msg_mode}, 1);
      rd(A_LO, d); chk("R6 readback kept", d, 32'h0000_1111);
      rd(A_ERR, d); chk("R6 err set", d, 1);
      handshake;
      chk("R6 no queued send", {31'b0, msg_valid}, 0);
      rd(A_ERR, d); chk("R7 err sticky", d, 1);
      wr(A_ERR, 32'h0);
      rd(A_ERR, d); chk("R7 err cleared", d, 0);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      wr(A_LO, 32'hFFFF_FFFF);
      rd(A_LO, d); chk("R8 ones busy", d, 32'h000C_D7FF);
      handshake;
      rd(A_LO, d); chk("R8 ones idle", d, 32'h000C_C7FF);
      wr(A_HI, 32'hFFFF_FFFF);
      rd(A_HI, d); chk("R2 hi reserved", d, 32'hFF00_0000);
   endtask

   task automatic t_hi_busy;
      logic [31:0] d;
      wr(A_HI, 32'h3300_0000);
      wr(A_LO, 32'h0000_0005);
      wr(A_HI, 32'h4400_0000);
      chk("R9 dest frozen", {24'b0, msg_dest}, 32'h33);
      rd(A_HI, d); chk("R9 staged", d, 32'h4400_0000);
      handshake;
      wr(A_LO, 32'h0000_0006);
      chk("R9 next launch", {24'b0, msg_dest}, 32'h44);
      handshake;
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      rd(12'h304, d); chk("R10 read zero", d, 0);
      wr(12'h304, 32'hFFFF_FFFF);
      chk("R10 no launch", {31'b0, msg_valid}, 0);
      rd(A_HI, d); chk("R10 hi intact", d, 32'h4400_0000);
      rd(A_LO, d); chk("R10 lo intact", d, 32'h0000_0006);
      rd(A_ERR, d); chk("R10 err intact", d, 0);
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_high;
      t_launch;
      t_shorthand;
      t_hold;
      t_busy_write;
      t_reserved;
      t_hi_busy;
      t_unmapped;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule